// File: doc/BRIEF.md
# Luma/Chroma Decimating Averaging Filter

This block sits behind three 8-bit video sample streams, one luma and two chroma, and puts each stream through a selectable filter. The luma lane either delays its samples by a fixed amount or averages adjacent pairs. The two chroma lanes offer the same two functions and also block averages over groups of four or eight samples, which prepare chroma for decimated output formats. The block produces one registered result per channel on every clock.

Block averages are aligned to a sync strobe. The sample captured while the strobe is high is position 0 of a group, and positions then count up by one per cycle. A chroma result is only defined on the cycle after a group completes. On that cycle a valid strobe is raised. On every other cycle in a block mode the chroma outputs keep their last value. Every average is rounded to 8 bits: a fractional part of one half or less rounds down, and anything above one half rounds up.

Sample index convention: x[k] is the value on an input when clock edge k captures it. y[n] is the output value just after edge n.

Top module: `yuv_decim_avg`

## Requirements
- R1: Pass-through. Luma with `luma_avg_i`=0, or chroma with `chroma_mode_i`=0, gives y[n] = x[n-3], a delay of three samples.
- R2: Pair average. Luma with `luma_avg_i`=1, or chroma with `chroma_mode_i`=1, gives y[n] = floor((x[n-4]+x[n-3])/2). An exact half rounds down. Its group delay is half a cycle longer than pass-through.
- R3: Quad average (`chroma_mode_i`=2). When x[n-2] sits at a group position whose low two bits are 3, the chroma output at n is the rounded quarter of x[n-5]+...+x[n-2].
- R4: Octet average (`chroma_mode_i`=3). When x[n-2] sits at group position 7, the chroma output at n is the rounded eighth of x[n-9]+...+x[n-2].
- R5: Block averages round half-down: with sum S over G samples, the result is S/G plus one only when the remainder times two exceeds G. An all-255 group gives 255 with no wrap.
- R6: A sample captured with `sync_i`=1 has group position 0. Each later cycle adds one, modulo 8. After reset the position starts at 0. A strobe in the middle of a group discards that partial group.
- R7: `blk_vld_o` is 1 on every cycle in chroma modes 0 and 1. In modes 2 and 3 it is 1 exactly on the cycles where R3 or R4 defines a result, and 0 otherwise. In mode 3 it is never high on two cycles in a row.
- R8: In chroma modes 2 and 3, `u_o` and `v_o` keep their previous value on every cycle where `blk_vld_o` is 0.
- R9: The luma output depends only on `luma_avg_i` and `y_i`. `chroma_mode_i` and `sync_i` have no effect on it.
- R10: While `rst_n` is low, and for the first two clock edges after it rises, all outputs are 0. Asserting `rst_n` clears the outputs at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| sync_i | input | 1 | Group phase strobe; the sample captured with it is position 0 |
| luma_avg_i | input | 1 | Luma function: 0 pass-through, 1 pair average |
| chroma_mode_i | input | 2 | Chroma function: 0 pass, 1 pair, 2 quad, 3 octet |
| y_i | input | 8 | Luma samples |
| u_i | input | 8 | First chroma samples |
| v_i | input | 8 | Second chroma samples |
| y_o | output | 8 | Filtered luma |
| u_o | output | 8 | Filtered first chroma |
| v_o | output | 8 | Filtered second chroma |
| blk_vld_o | output | 1 | Chroma result defined on this cycle |

## Verification
The bench builds the block with its defaults: 8-bit samples, a maximum group of eight, and a three-sample pass-through latency. This makes the 11-bit accumulator, the wrap of the 3-bit phase counter and the octet mode all reachable. The constant-255 octet case therefore tests the top of the accumulator range. The sync periods used are 8, 6 and 11, so groups are cut off partway and the phase restarts. Binary bit patterns place remainders of exactly one half and of three quarters inside quad groups, to check which way the rounding goes.

// File: rtl/yuvavg_pkg.sv
package yuvavg_pkg;
  typedef enum logic [1:0] {
    CM_PASS = 2'd0,
    CM_PAIR = 2'd1,
    CM_QUAD = 2'd2,
    CM_OCT  = 2'd3
  } cmode_e;
endpackage

// File: rtl/yuvavg_round.sv
// Divide by 2**shift_i with round-half-down on the discarded bits.
module yuvavg_round #(
  parameter int IW = 11,
  parameter int OW = 8,
  parameter int SW = 2
) (
  input  logic [IW-1:0] sum_i,
  input  logic [SW-1:0] shift_i,
  output logic [OW-1:0] avg_o
);
  localparam logic [IW-1:0] ONE = IW'(1);

  logic [IW-1:0] quo;
  logic [IW-1:0] msk;
  logic [IW-1:0] frc;
  logic [IW-1:0] hlf;
  logic [IW-1:0] res;
  logic          up;
  logic          unused_hi;

  always_comb begin
    quo = sum_i >> shift_i;
    msk = (ONE << shift_i) - ONE;
    frc = sum_i & msk;
    hlf = (msk + ONE) >> 1;
    up  = (frc > hlf);
    res = quo + {{(IW-1){1'b0}}, up};
  end

  assign avg_o     = res[OW-1:0];
  assign unused_hi = ^res[IW-1:OW];
endmodule

// File: rtl/yuvavg_phase.sv
// Group position counter, forced to 0 by the sync strobe.
module yuvavg_phase #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  output logic [PW-1:0] pos_o
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;

  always_comb begin
    pos_o = sync_i ? '0 : cnt_q;
    cnt_d = pos_o + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/yuvavg_tap.sv
// Delay line giving the pass-through sample and the rounded pair average.
module yuvavg_tap #(
  parameter int DW  = 8,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] x_i,
  input  logic          pair_i,
  output logic [DW-1:0] nxt_o
);
  localparam int DEPTH = LAT + 1;

  logic [DW-1:0] d_q [DEPTH];
  logic [DW:0]   pair_sum;
  logic [DW-1:0] pair_avg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) d_q[i] <= '0;
    end else begin
      d_q[0] <= x_i;
      for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
    end
  end

  always_comb begin
    pair_sum = {1'b0, d_q[LAT-1]} + {1'b0, d_q[LAT]};
  end

  yuvavg_round #(.IW(DW+1), .OW(DW), .SW(1)) u_rnd (
    .sum_i   (pair_sum),
    .shift_i (1'b1),
    .avg_o   (pair_avg)
  );

  assign nxt_o = pair_i ? pair_avg : d_q[LAT-1];
endmodule

// File: rtl/yuvavg_blk.sv
// Running group accumulator with a registered, rounded block result.
module yuvavg_blk #(
  parameter int DW = 8,
  parameter int GL = 3,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] x_i,
  input  logic [GL-1:0] pos_i,
  input  logic [SW-1:0] shift_i,
  output logic [DW-1:0] rnd_o,
  output logic          vld_o
);
  localparam int AW = DW + GL;
  localparam logic [GL-1:0] PONE = GL'(1);

  logic [GL-1:0] pmsk;
  logic          first;
  logic          last;
  logic [AW-1:0] xw;
  logic [AW-1:0] acc_d, acc_q;
  logic [AW-1:0] sum_q;
  logic [SW-1:0] sh_q;
  logic          last_q;
  logic [DW-1:0] rnd_w, rnd_q;
  logic          vld_q;

  always_comb begin
    pmsk  = (PONE << shift_i) - PONE;
    first = ((pos_i & pmsk) == '0);
    last  = ((pos_i & pmsk) == pmsk);
    xw    = {{GL{1'b0}}, x_i};
    acc_d = first ? xw : (acc_q + xw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      last_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      last_q <= last;
      vld_q  <= last_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      sh_q  <= '0;
    end else if (last) begin
      sum_q <= acc_d;
      sh_q  <= shift_i;
    end
  end

  yuvavg_round #(.IW(AW), .OW(DW), .SW(SW)) u_rnd (
    .sum_i   (sum_q),
    .shift_i (sh_q),
    .avg_o   (rnd_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rnd_q <= '0;
    else if (last_q) rnd_q <= rnd_w;
  end

  assign rnd_o = rnd_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/yuv_decim_avg.sv
module yuv_decim_avg #(
  parameter int DW  = 8,
  parameter int GL  = 3,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic          luma_avg_i,
  input  logic [1:0]    chroma_mode_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] u_i,
  input  logic [DW-1:0] v_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] u_o,
  output logic [DW-1:0] v_o,
  output logic          blk_vld_o
);
  import yuvavg_pkg::*;

  localparam int NCH = 2;
  localparam int SW  = $clog2(GL + 1);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  // mode decode
  cmode_e        cm;
  logic          blk_mode;
  logic          pair_c;
  logic [SW-1:0] blk_shift;

  always_comb begin
    cm        = cmode_e'(chroma_mode_i);
    blk_mode  = (cm == CM_QUAD) || (cm == CM_OCT);
    pair_c    = (cm == CM_PAIR);
    blk_shift = (cm == CM_QUAD) ? SW'(GL - 1) : SW'(GL);
  end

  // shared group phase
  logic [GL-1:0] pos;

  yuvavg_phase #(.PW(GL)) u_phase (
    .clk    (clk),
    .rst_n  (rst_q),
    .sync_i (sync_i),
    .pos_o  (pos)
  );

  // luma lane
  logic [DW-1:0] y_nxt;
  logic [DW-1:0] y_q;

  yuvavg_tap #(.DW(DW), .LAT(LAT)) u_ytap (
    .clk    (clk),
    .rst_n  (rst_q),
    .x_i    (y_i),
    .pair_i (luma_avg_i),
    .nxt_o  (y_nxt)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) y_q <= '0;
    else        y_q <= y_nxt;
  end

  // chroma lanes
  logic [DW-1:0] c_in  [NCH];
  logic [DW-1:0] t_nxt [NCH];
  logic [DW-1:0] b_rnd [NCH];
  logic          b_vld [NCH];
  logic [DW-1:0] c_d   [NCH];
  logic          c_ce  [NCH];
  logic [DW-1:0] c_q   [NCH];

  assign c_in[0] = u_i;
  assign c_in[1] = v_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    yuvavg_tap #(.DW(DW), .LAT(LAT)) u_tap (
      .clk    (clk),
      .rst_n  (rst_q),
      .x_i    (c_in[c]),
      .pair_i (pair_c),
      .nxt_o  (t_nxt[c])
    );

    yuvavg_blk #(.DW(DW), .GL(GL), .SW(SW)) u_blk (
      .clk     (clk),
      .rst_n   (rst_q),
      .x_i     (c_in[c]),
      .pos_i   (pos),
      .shift_i (blk_shift),
      .rnd_o   (b_rnd[c]),
      .vld_o   (b_vld[c])
    );

    always_comb begin
      c_ce[c] = !blk_mode || b_vld[c];
      c_d[c]  = blk_mode ? b_rnd[c] : t_nxt[c];
    end

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q)       c_q[c] <= '0;
      else if (c_ce[c]) c_q[c] <= c_d[c];
    end
  end

  // valid strobe
  logic vld_d, vld_q;

  always_comb begin
    vld_d = blk_mode ? b_vld[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign y_o       = y_q;
  assign u_o       = c_q[0];
  assign v_o       = c_q[1];
  assign blk_vld_o = vld_q;
endmodule

// File: rtl/yuvavg_chk.sv
module yuvavg_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_q,
  input logic          luma_avg_i,
  input logic [1:0]    chroma_mode_i,
  input logic [DW-1:0] y_i,
  input logic [DW-1:0] y_o,
  input logic [DW-1:0] u_o,
  input logic [DW-1:0] v_o,
  input logic          blk_vld_o
);
  // active edges since the internal reset released, saturating
  logic [3:0] age_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)              age_q <= 4'd0;
    else if (age_q != 4'hF)  age_q <= age_q + 4'd1;
  end

  assert_luma_pass_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (age_q >= 4'd6 && !$past(luma_avg_i)) |-> (y_o == $past(y_i, 4)));

  assert_luma_pair_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (age_q >= 4'd6 && $past(luma_avg_i)) |->
      ({1'b0, y_o} == (({1'b0, $past(y_i, 4)} + {1'b0, $past(y_i, 5)}) >> 1)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (age_q >= 4'd2 && $past(chroma_mode_i[1]) && !blk_vld_o) |->
      ($stable(u_o) && $stable(v_o)));

  assert_vld_full_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (age_q >= 4'd2 && !$past(chroma_mode_i[1])) |-> blk_vld_o);

  assert_oct_gap_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (age_q >= 4'd6 && chroma_mode_i == 2'd3 && $past(chroma_mode_i) == 2'd3 && blk_vld_o)
      |=> !blk_vld_o);
endmodule

bind yuv_decim_avg yuvavg_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_q         (rst_q),
  .luma_avg_i    (luma_avg_i),
  .chroma_mode_i (chroma_mode_i),
  .y_i           (y_i),
  .y_o           (y_o),
  .u_o           (u_o),
  .v_o           (v_o),
  .blk_vld_o     (blk_vld_o)
);

// File: tb/sim_yuv_decim_avg.sv
`timescale 1ns/1ps
module sim_yuv_decim_avg;
  localparam int NENT = 8;
  localparam int NCYC = 80;
  localparam int SKIP = 12;
  localparam int HMAX = 4096;

  typedef struct packed {
    logic       lavg;
    logic [1:0] cm;
    logic [7:0] sper;
    logic       kind;
    logic [7:0] yb, ys, ub, us, vb, vs;
  } vec_t;

  // stimulus vectors: expected results come from the model below
  localparam vec_t TBL [NENT] = '{
    '{1'b0, 2'd0, 8'd0,  1'b0, 8'd10,  8'd3,   8'd200, 8'd7,  8'd50,  8'd250},
    '{1'b1, 2'd1, 8'd0,  1'b0, 8'd0,   8'd17,  8'd3,   8'd5,  8'd255, 8'd1},
    '{1'b0, 2'd2, 8'd8,  1'b0, 8'd40,  8'd9,   8'd0,   8'd13, 8'd77,  8'd29},
    '{1'b1, 2'd3, 8'd8,  1'b0, 8'd99,  8'd31,  8'd1,   8'd3,  8'd250, 8'd11},
    '{1'b1, 2'd2, 8'd6,  1'b0, 8'd5,   8'd1,   8'd128, 8'd37, 8'd9,   8'd91},
    '{1'b0, 2'd3, 8'd11, 1'b0, 8'd200, 8'd5,   8'd60,  8'd23, 8'd17,  8'd201},
    '{1'b0, 2'd3, 8'd8,  1'b0, 8'd255, 8'd0,   8'd255, 8'd0,  8'd255, 8'd0},
    '{1'b1, 2'd2, 8'd8,  1'b1, 8'h5A,  8'd200, 8'h0C,  8'd1,  8'h0E,  8'd1}
  };

  logic       clk;
  logic       rst_n;
  logic       sync_i;
  logic       luma_avg_i;
  logic [1:0] chroma_mode_i;
  logic [7:0] y_i, u_i, v_i;
  logic [7:0] y_o, u_o, v_o;
  logic       blk_vld_o;

  yuv_decim_avg u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_i        (sync_i),
    .luma_avg_i    (luma_avg_i),
    .chroma_mode_i (chroma_mode_i),
    .y_i           (y_i),
    .u_i           (u_i),
    .v_i           (v_i),
    .y_o           (y_o),
    .u_o           (u_o),
    .v_o           (v_o),
    .blk_vld_o     (blk_vld_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // reference model state
  int hist [0:2][0:HMAX-1];
  int hp   [0:HMAX-1];
  int n        = 0;
  int pos_prev = 0;
  int exp_y    = 0;
  int exp_c [0:1] = '{0, 0};
  int exp_v    = 0;

  function automatic int gx(int ch, int idx);
    if (idx < 0) return 0;
    return hist[ch][idx];
  endfunction

  function automatic int rnd(int s, int g);
    int q = s / g;
    int r = s % g;
    if (2 * r > g) q++;
    return q;
  endfunction

  function automatic int smp(int kind, int base, int step, int j);
    if (kind == 0) return (base + step * j) % 256;
    return ((base >> (j % 8)) & 1) ? step : 0;
  endfunction

  function automatic string ctag(int cm);
    case (cm)
      0:       return "R1";
      1:       return "R2";
      2:       return "R3 R5 R6 R8";
      default: return "R4 R5 R6 R8";
    endcase
  endfunction

  task automatic chk(string tag, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  // advance the model by the edge that just captured the current inputs
  task automatic model_edge();
    int p, g;
    bit v;
    hist[0][n] = y_i;
    hist[1][n] = u_i;
    hist[2][n] = v_i;
    p = sync_i ? 0 : pos_prev;
    hp[n] = p;
    pos_prev = (p + 1) % 8;
    exp_y = luma_avg_i ? rnd(gx(0, n-4) + gx(0, n-3), 2) : gx(0, n-3);
    if (chroma_mode_i < 2) begin
      for (int c = 0; c < 2; c++)
        exp_c[c] = (chroma_mode_i == 0) ? gx(c+1, n-3)
                                        : rnd(gx(c+1, n-4) + gx(c+1, n-3), 2);
      exp_v = 1;
    end else begin
      g = (chroma_mode_i == 2) ? 4 : 8;
      v = (n >= 2) && ((hp[n-2] % g) == g - 1);
      if (v) begin
        for (int c = 0; c < 2; c++) begin
          int s = 0;
          for (int i = n - g - 1; i <= n - 2; i++) s += gx(c+1, i);
          exp_c[c] = rnd(s, g);
        end
      end
      exp_v = v ? 1 : 0;
    end
    n++;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sync_i = 1'b0;
    luma_avg_i = 1'b0;
    chroma_mode_i = 2'd0;
    y_i = 8'd0; u_i = 8'd0; v_i = 8'd0;

    // reset state with toggling inputs (R10)
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      y_i = 8'(i * 40 + 7); u_i = 8'(i * 9 + 3); v_i = 8'(255 - i);
      chroma_mode_i = 2'(i);
      sync_i = i[0];
      chk("R10 y reset", y_o, 0);
      chk("R10 u reset", u_o, 0);
      chk("R10 vld reset", blk_vld_o, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    y_i = 8'd0; u_i = 8'd0; v_i = 8'd0;
    sync_i = 1'b0; chroma_mode_i = 2'd0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 y after 1st edge", y_o, 0);
    chk("R10 vld after 1st edge", blk_vld_o, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 vld after 2nd edge", blk_vld_o, 0);
    chk("R10 v after 2nd edge", v_o, 0);

    // vector table walk
    for (int e = 0; e < NENT; e++) begin
      for (int j = 0; j < NCYC; j++) begin
        if (j >= SKIP) begin
          chk(TBL[e].cm >= 2 ? "R9 luma" : (TBL[e].lavg ? "R2 luma" : "R1 luma"),
              y_o, exp_y);
          chk({ctag(int'(TBL[e].cm)), " u"}, u_o, exp_c[0]);
          chk({ctag(int'(TBL[e].cm)), " v"}, v_o, exp_c[1]);
          chk("R7 valid", blk_vld_o, exp_v);
        end
        luma_avg_i    = TBL[e].lavg;
        chroma_mode_i = TBL[e].cm;
        sync_i = (j == 0) || (TBL[e].sper != 0 && (j % int'(TBL[e].sper)) == 0);
        y_i = 8'(smp(0, int'(TBL[e].yb), int'(TBL[e].ys), j));
        u_i = 8'(smp(int'(TBL[e].kind), int'(TBL[e].ub), int'(TBL[e].us), j));
        v_i = 8'(smp(int'(TBL[e].kind), int'(TBL[e].vb), int'(TBL[e].vs), j));
        @(posedge clk);
        model_edge();
        @(negedge clk);
      end
    end

    // directed: half remainder in quad mode rounds down, three quarters rounds up (R5)
    chk("R5 quad half down u", u_o, 0);
    chk("R5 quad three quarters up v", v_o, 1);

    // directed: asynchronous reset clears outputs at once (R10)
    #1;
    rst_n = 1'b0;
    #1;
    chk("R10 async y", y_o, 0);
    chk("R10 async v", v_o, 0);
    chk("R10 async vld", blk_vld_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule